// File: doc/BRIEF.md
# Eight-bit multi-cycle processor core

This block is a small processor with an 8-bit datapath, four general-purpose registers (R0 to R3) and separate instruction and data memories. Each 16-bit instruction passes through a shared phase sequencer, one phase per clock: fetch, decode, execute, an optional memory phase, and an optional write-back. How many phases an instruction uses depends on its class, so instructions take different numbers of cycles. Only one instruction is in flight at a time.

Instruction fields are opcode[15:12], destination Rd[11:10], source Rs[9:8] and immediate imm[7:0]. The opcodes are: 0 LOAD (Rd <- M[imm]), 1 STORE (M[imm] <- Rs), 2 ADD (Rd <- Rd+Rs), 3 SUB (Rd <- Rd-Rs), 4 AND, 5 OR, 6 MOV (Rd <- Rs), 7 LDI (Rd <- imm), 8 SUBI (Rd <- Rd-imm), 9 BNZ (branch to the absolute address imm when Z is clear), and 15 HALT. Any other code runs as a no-operation. The instruction memory and data memory both have combinational read ports. A store is written at the clock edge that ends its memory phase.

The flags Z, C and N are held in a register that only the arithmetic and logic instructions update. As a result, a load or store placed between an operation and a branch does not change the branch decision. A status output shows when the core has halted. The program counter, the registers and the flags are brought out so that a bench can observe them.

Top module: `mc8_core`

## Requirements
- R1: In the fetch phase the word at `imem_addr` (= PC) is captured as the current instruction and the PC increments by one (mod 256).
- R2: Cycles per instruction: ADD, SUB, AND, OR, MOV, LDI, SUBI take 4; LOAD 5; STORE 4; BNZ 3 whether taken or not; HALT 2; an undefined opcode 3. The register result becomes visible at the end of the last cycle.
- R3: Results: ADD, SUB, AND and OR combine Rd and Rs modulo 256. SUBI computes Rd-imm. MOV copies Rs. LDI loads imm.
- R4: While `rst` is high at a clock edge, all registers become 0, the PC becomes 0, the flags become 0, `halted` becomes 0, and the next phase is fetch.
- R5: HALT raises `halted` two cycles after it is fetched. After that the PC (one past the HALT address), the registers and `halted` never change until reset.
- R6: `dbg_flags` is {N,C,Z} (bit 2 = N, bit 1 = C, bit 0 = Z). ADD, SUB, SUBI, AND and OR set Z = (result==0) and N = result bit 7. C is the carry out for ADD, the borrow (first operand < second operand, unsigned) for SUB and SUBI, and 0 for AND and OR. No other instruction changes the flags.
- R7: BNZ loads the PC with imm when the held Z is 0. Otherwise the PC keeps the incremented value.
- R8: `dmem_re` is high only in the fourth cycle of a LOAD, and `dmem_we` only in the fourth cycle of a STORE, with `dmem_addr` = imm and `dmem_wdata` = Rs. The two are never high together.
- R9: A register written by one instruction is read with its new value by the very next instruction.
- R10: An undefined opcode changes no register, no flag and no memory location. It only advances the PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction memory address (the PC) |
| imem_data | input | 16 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 8 | Data memory address |
| dmem_wdata | output | 8 | Data memory write data |
| dmem_rdata | input | 8 | Data memory read data at `dmem_addr`, combinational |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_re | output | 1 | Data memory read strobe |
| halted | output | 1 | Core is in its terminal state |
| dbg_pc | output | 8 | Current program counter |
| dbg_regs | output | 32 | R0 in bits 7:0 up to R3 in bits 31:24 |
| dbg_flags | output | 3 | {N,C,Z} flag register |

## Verification
The hardest situation to reach is one where the flags must survive a store and a load that sit between the operation that set them and the branch that reads them. The flags also have to match the prediction while no register changes. To reach it, the stimulus programs place SUB, STORE, LOAD and BNZ in that order, so that the not-taken path proves Z was held. A later OR with a nonzero result is followed by a BNZ that is taken, which covers the opposite case. A load whose result is used at once, an undefined opcode and a MOV after a borrowing SUBI fill in the other flag corners. The bench's behavioural model predicts each instruction's retirement cycle from its class. Every clock it compares registers, memory strobes and `halted`, so any shift in phase count shows up as a register that changes one cycle early or late.

// File: rtl/mc8_pkg.sv
package mc8_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int INSTR_W   = 16;
  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int OPC_W     = 4;
  localparam int OPC_LSB   = INSTR_W - OPC_W;
  localparam int RD_LSB    = OPC_LSB - REG_IDX_W;
  localparam int RS_LSB    = RD_LSB - REG_IDX_W;
  localparam int IMM_W     = RS_LSB;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'h3;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_OR    = 4'h5;
  localparam logic [OPC_W-1:0] OPC_MOV   = 4'h6;
  localparam logic [OPC_W-1:0] OPC_LDI   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_SUBI  = 4'h8;
  localparam logic [OPC_W-1:0] OPC_BNZ   = 4'h9;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4,
    PH_HALT   = 3'd5
  } phase_e;

  typedef struct packed {
    logic n;
    logic c;
    logic z;
  } flags_t;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic reg_wr;
    logic flag_wr;
    logic branch;
    logic halt;
  } ictl_t;

  typedef struct packed {
    logic [DATA_W-1:0] y;
    logic              c;
  } alu_out_t;

  // Class of an opcode: which phases and side effects it needs.
  function automatic ictl_t classify(input logic [OPC_W-1:0] op);
    ictl_t k;
    k = '0;
    case (op)
      OPC_LOAD:  begin k.mem_rd = 1'b1; k.reg_wr = 1'b1; end
      OPC_STORE: k.mem_wr = 1'b1;
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_SUBI: begin
        k.reg_wr  = 1'b1;
        k.flag_wr = 1'b1;
      end
      OPC_MOV, OPC_LDI: k.reg_wr = 1'b1;
      OPC_BNZ:  k.branch = 1'b1;
      OPC_HALT: k.halt   = 1'b1;
      default:  k = '0;
    endcase
    return k;
  endfunction

  // Arithmetic of the execute phase. C is carry for addition, borrow for subtraction.
  function automatic alu_out_t alu_eval(input logic [OPC_W-1:0]  op,
                                        input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [IMM_W-1:0]  imm);
    alu_out_t r;
    logic [DATA_W:0] wide;
    r    = '0;
    wide = '0;
    case (op)
      OPC_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        r.y  = wide[DATA_W-1:0];
        r.c  = wide[DATA_W];
      end
      OPC_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        r.y  = wide[DATA_W-1:0];
        r.c  = wide[DATA_W];
      end
      OPC_SUBI: begin
        wide = {1'b0, a} - {1'b0, DATA_W'(imm)};
        r.y  = wide[DATA_W-1:0];
        r.c  = wide[DATA_W];
      end
      OPC_AND:  r.y = a & b;
      OPC_OR:   r.y = a | b;
      OPC_MOV:  r.y = b;
      OPC_LDI, OPC_LOAD, OPC_STORE: r.y = DATA_W'(imm);
      default:  r.y = '0;
    endcase
    return r;
  endfunction

  function automatic flags_t flags_of(input alu_out_t r);
    flags_t f;
    f.z = (r.y == '0);
    f.n = r.y[DATA_W-1];
    f.c = r.c;
    return f;
  endfunction

endpackage

// File: rtl/mc8_regfile.sv
module mc8_regfile #(
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [IDX_W-1:0]   raddr_a,
  input  logic [IDX_W-1:0]   raddr_b,
  output logic [DW-1:0]      rdata_a,
  output logic [DW-1:0]      rdata_b,
  output logic [NREG*DW-1:0] flat
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (we && (waddr == IDX_W'(g))) begin
        regs_q[g] <= wdata;
      end
    end
    assign flat[g*DW +: DW] = regs_q[g];
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/mc8_alu.sv
module mc8_alu
  import mc8_pkg::*;
(
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] y,
  output flags_t            flags
);

  alu_out_t res;

  always_comb begin
    res   = alu_eval(op, a, b, imm);
    y     = res.y;
    flags = flags_of(res);
  end

endmodule

// File: rtl/mc8_seq.sv
module mc8_seq
  import mc8_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   is_mem,
  input  logic   is_load,
  input  logic   writes_reg,
  input  logic   is_halt,
  output phase_e phase
);

  phase_e nxt;

  always_comb begin
    case (phase)
      PH_FETCH:  nxt = PH_DECODE;
      PH_DECODE: nxt = is_halt ? PH_HALT : PH_EXEC;
      PH_EXEC:   nxt = is_mem ? PH_MEM : (writes_reg ? PH_WB : PH_FETCH);
      PH_MEM:    nxt = is_load ? PH_WB : PH_FETCH;
      PH_WB:     nxt = PH_FETCH;
      PH_HALT:   nxt = PH_HALT;
      default:   nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= nxt;
  end

endmodule

// File: rtl/mc8_core.sv
module mc8_core
  import mc8_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  output logic [ADDR_W-1:0]          imem_addr,
  input  logic [INSTR_W-1:0]         imem_data,
  output logic [ADDR_W-1:0]          dmem_addr,
  output logic [DATA_W-1:0]          dmem_wdata,
  input  logic [DATA_W-1:0]          dmem_rdata,
  output logic                       dmem_we,
  output logic                       dmem_re,
  output logic                       halted,
  output logic [ADDR_W-1:0]          dbg_pc,
  output logic [NUM_REGS*DATA_W-1:0] dbg_regs,
  output logic [2:0]                 dbg_flags
);

  phase_e               phase;
  logic [ADDR_W-1:0]    pc_q;
  logic [INSTR_W-1:0]   ir_q;
  logic [DATA_W-1:0]    opa_q, opb_q, res_q, mdr_q;
  flags_t               flg_q;

  logic [OPC_W-1:0]     ir_op;
  logic [REG_IDX_W-1:0] ir_rd, ir_rs;
  logic [IMM_W-1:0]     ir_imm;
  ictl_t                ctl;

  logic [DATA_W-1:0]    rd_a, rd_b, alu_y, wb_data;
  flags_t               alu_flags;

  // Named internal events, observed by the checker
  logic ev_fetch, ev_decode, ev_exec, ev_flag_upd, ev_br_taken, ev_rf_we;

  assign ir_op  = ir_q[OPC_LSB +: OPC_W];
  assign ir_rd  = ir_q[RD_LSB +: REG_IDX_W];
  assign ir_rs  = ir_q[RS_LSB +: REG_IDX_W];
  assign ir_imm = ir_q[IMM_W-1:0];
  assign ctl    = classify(ir_op);

  assign ev_fetch    = (phase == PH_FETCH);
  assign ev_decode   = (phase == PH_DECODE);
  assign ev_exec     = (phase == PH_EXEC);
  assign ev_flag_upd = ev_exec && ctl.flag_wr;
  assign ev_br_taken = ev_exec && ctl.branch && !flg_q.z;
  assign ev_rf_we    = (phase == PH_WB) && ctl.reg_wr;

  mc8_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .is_mem     (ctl.mem_rd | ctl.mem_wr),
    .is_load    (ctl.mem_rd),
    .writes_reg (ctl.reg_wr),
    .is_halt    (ctl.halt),
    .phase      (phase)
  );

  mc8_regfile #(
    .NREG (NUM_REGS),
    .DW   (DATA_W)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ev_rf_we),
    .waddr   (ir_rd),
    .wdata   (wb_data),
    .raddr_a (ir_rd),
    .raddr_b (ir_rs),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .flat    (dbg_regs)
  );

  mc8_alu u_alu (
    .op    (ir_op),
    .a     (opa_q),
    .b     (opb_q),
    .imm   (ir_imm),
    .y     (alu_y),
    .flags (alu_flags)
  );

  assign wb_data = ctl.mem_rd ? mdr_q : res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
      mdr_q <= '0;
      flg_q <= '0;
    end else begin
      if (ev_fetch) begin
        ir_q <= imem_data;
        pc_q <= pc_q + 1'b1;
      end
      if (ev_decode) begin
        opa_q <= rd_a;
        opb_q <= rd_b;
      end
      if (ev_exec) begin
        res_q <= alu_y;
      end
      if (ev_flag_upd) begin
        flg_q <= alu_flags;
      end
      if (ev_br_taken) begin
        pc_q <= ADDR_W'(ir_imm);
      end
      if ((phase == PH_MEM) && ctl.mem_rd) begin
        mdr_q <= dmem_rdata;
      end
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = ADDR_W'(res_q);
  assign dmem_wdata = opb_q;
  assign dmem_we    = (phase == PH_MEM) && ctl.mem_wr;
  assign dmem_re    = (phase == PH_MEM) && ctl.mem_rd;
  assign halted     = (phase == PH_HALT);
  assign dbg_pc     = pc_q;
  assign dbg_flags  = {flg_q.n, flg_q.c, flg_q.z};

endmodule

// File: rtl/mc8_core_chk.sv
module mc8_core_chk
  import mc8_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input phase_e            phase,
  input logic [ADDR_W-1:0] pc,
  input logic [2:0]        flags,
  input logic              halted,
  input logic              dmem_we,
  input logic              dmem_re,
  input logic              rf_we,
  input logic              br_taken,
  input logic [IMM_W-1:0]  imm
);

  // R4: reset returns to a fetch at address 0
  a_r4_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0) && (phase == PH_FETCH) && !halted && (flags == 3'b000));

  // R1: every fetch advances the PC by one
  a_r1_pc_advance: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R5: halted is terminal and freezes the PC
  a_r5_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc));

  // R6: flags change only across an execute phase
  a_r6_flags_exec_only: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_EXEC) |=> $stable(flags));

  // R7: a taken branch lands on its immediate
  a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == ADDR_W'($past(imm))));

  // R8: read and write strobes are exclusive
  a_r8_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  // R2: write-back follows an execute or memory phase
  a_r2_wb_order: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(phase) == PH_EXEC) || ($past(phase) == PH_MEM));

endmodule

bind mc8_core mc8_core_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .phase    (phase),
  .pc       (pc_q),
  .flags    (dbg_flags),
  .halted   (halted),
  .dmem_we  (dmem_we),
  .dmem_re  (dmem_re),
  .rf_we    (ev_rf_we),
  .br_taken (ev_br_taken),
  .imm      (ir_imm)
);

// File: tb/mc8_core_tb.sv
`timescale 1ns/1ps
module mc8_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr, dmem_addr, dmem_wdata, dmem_rdata, dbg_pc;
  logic [15:0] imem_data;
  logic        dmem_we, dmem_re, halted;
  logic [31:0] dbg_regs;
  logic [2:0]  dbg_flags;

  logic [15:0] imem_b [256];
  logic [7:0]  dmem_b [256];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign imem_data  = imem_b[imem_addr];
  assign dmem_rdata = dmem_b[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem_b[dmem_addr] <= dmem_wdata;

  mc8_core dut_i (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_regs(dbg_regs), .dbg_flags(dbg_flags)
  );

  // Behavioural reference state
  logic [7:0] rm [4];
  logic [7:0] dmm [256];
  logic [7:0] pcm;
  logic       mz, mc, mn, hm;
  int         cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int latency(input logic [3:0] op);
    case (op)
      4'h0: return 5;
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: return 4;
      4'h9: return 3;
      4'hF: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic set_zn(input logic [7:0] v);
    mz = (v == 8'h00);
    mn = v[7];
  endtask

  task automatic retire(input logic [15:0] w);
    logic [3:0] op;
    logic [1:0] rd, rs;
    logic [7:0] im;
    int t;
    op = w[15:12]; rd = w[11:10]; rs = w[9:8]; im = w[7:0];
    pcm = pcm + 8'd1;
    case (op)
      4'h0: rm[rd] = dmm[im];
      4'h1: begin
        dmm[im] = rm[rs];
        chk(dmem_b[im] == dmm[im], "R8 stored byte", dmem_b[im], dmm[im]);
      end
      4'h2: begin t = rm[rd] + rm[rs]; mc = (t > 255); rm[rd] = t[7:0]; set_zn(rm[rd]); end
      4'h3: begin mc = (rm[rd] < rm[rs]); rm[rd] = rm[rd] - rm[rs]; set_zn(rm[rd]); end
      4'h4: begin mc = 1'b0; rm[rd] = rm[rd] & rm[rs]; set_zn(rm[rd]); end
      4'h5: begin mc = 1'b0; rm[rd] = rm[rd] | rm[rs]; set_zn(rm[rd]); end
      4'h6: rm[rd] = rm[rs];
      4'h7: rm[rd] = im;
      4'h8: begin mc = (rm[rd] < im); rm[rd] = rm[rd] - im; set_zn(rm[rd]); end
      4'h9: if (!mz) pcm = im;
      4'hF: hm = 1'b1;
      default: ; // R10: no effect beyond the PC
    endcase
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) begin
      imem_b[i] = 16'hF000;
      dmem_b[i] = 8'h00;
      dmm[i]    = 8'h00;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dbg_pc == 8'h00, "R4 pc after reset", dbg_pc, 0);
    chk(dbg_regs == 32'h0, "R4 regs after reset", dbg_regs, 0);
    chk(dbg_flags == 3'b000, "R4 flags after reset", dbg_flags, 0);
    chk(halted == 1'b0, "R4 halted after reset", halted, 0);
    for (int i = 0; i < 4; i++) rm[i] = 8'h00;
    pcm = 8'h00; mz = 0; mc = 0; mn = 0; hm = 0; cnt = 0;
    rst = 1'b0;
  endtask

  task automatic run_prog(input int limit);
    int cyc = 0;
    int post = 0;
    logic [15:0] w;
    bit exp_we, exp_re;
    do_reset();
    while (post < 20) begin
      @(negedge clk);
      cyc++;
      if (cyc > limit) begin
        chk(0, "WATCHDOG program did not halt", cyc, limit);
        break;
      end
      if (!hm) begin
        cnt++;
        w = imem_b[pcm];
        exp_re = (w[15:12] == 4'h0) && (cnt == 3);
        exp_we = (w[15:12] == 4'h1) && (cnt == 3);
        chk(dmem_re == exp_re, "R8 read strobe", dmem_re, exp_re);
        chk(dmem_we == exp_we, "R8 write strobe", dmem_we, exp_we);
        if (exp_we || exp_re)
          chk(dmem_addr == w[7:0], "R8 data address", dmem_addr, w[7:0]);
        if (exp_we)
          chk(dmem_wdata == rm[w[9:8]], "R8 write data", dmem_wdata, rm[w[9:8]]);
        if (cnt == latency(w[15:12])) begin
          retire(w);
          cnt = 0;
          chk(dbg_pc == pcm, "R1 R7 pc at instruction boundary", dbg_pc, pcm);
          chk(dbg_flags == {mn, mc, mz}, "R6 flags at instruction boundary",
              dbg_flags, {mn, mc, mz});
        end
      end else begin
        post++;
        chk(dbg_pc == pcm, "R5 pc frozen after halt", dbg_pc, pcm);
        chk(dmem_we == 1'b0 && dmem_re == 1'b0, "R5 no memory access after halt",
            {dmem_we, dmem_re}, 0);
      end
      for (int i = 0; i < 4; i++)
        chk(dbg_regs[8*i +: 8] == rm[i], "R2 R3 R9 R10 register timing/value",
            dbg_regs[8*i +: 8], rm[i]);
      chk(halted == hm, "R5 halted status", halted, hm);
    end
  endtask

  initial begin
    #800000;
    chk(0, "WATCHDOG global timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Program A: Fibonacci count-down from 6
    clear_mems();
    imem_b[0] = 16'h7001; // LDI R0,1
    imem_b[1] = 16'h7401; // LDI R1,1
    imem_b[2] = 16'h7806; // LDI R2,6
    imem_b[3] = 16'h6C00; // MOV R3,R0
    imem_b[4] = 16'h2D00; // ADD R3,R1
    imem_b[5] = 16'h6100; // MOV R0,R1
    imem_b[6] = 16'h6700; // MOV R1,R3
    imem_b[7] = 16'h8801; // SUBI R2,1
    imem_b[8] = 16'h9003; // BNZ 3
    imem_b[9] = 16'hF000; // HALT
    run_prog(2000);
    chk(dbg_regs[7:0]   == 8'd13, "R3 fib R0", dbg_regs[7:0], 13);
    chk(dbg_regs[15:8]  == 8'd21, "R3 fib R1", dbg_regs[15:8], 21);
    chk(dbg_regs[23:16] == 8'd0,  "R7 fib loop counter", dbg_regs[23:16], 0);
    chk(dbg_regs[31:24] == 8'd21, "R3 fib R3", dbg_regs[31:24], 21);
    chk(dbg_pc == 8'd10, "R5 pc one past halt", dbg_pc, 10);
    chk(halted == 1'b1, "R5 halted at end", halted, 1);

    // Program B: flags across memory ops, load-use, branches, undefined opcode
    clear_mems();
    imem_b[0]  = 16'h7005; // LDI R0,5
    imem_b[1]  = 16'h7405; // LDI R1,5
    imem_b[2]  = 16'h3100; // SUB R0,R1   -> 0, Z=1
    imem_b[3]  = 16'h1110; // STORE [10],R1
    imem_b[4]  = 16'h0810; // LOAD R2,[10]
    imem_b[5]  = 16'h900C; // BNZ 12 (not taken, Z held)
    imem_b[6]  = 16'h2A00; // ADD R2,R2   -> 10 (load-use)
    imem_b[7]  = 16'hA000; // undefined
    imem_b[8]  = 16'h7C80; // LDI R3,80
    imem_b[9]  = 16'h2F00; // ADD R3,R3   -> 0, C=1 Z=1
    imem_b[10] = 16'h5E00; // OR R3,R2    -> 10
    imem_b[11] = 16'h900D; // BNZ 13 (taken)
    imem_b[12] = 16'h70EE; // skipped
    imem_b[13] = 16'h4D00; // AND R3,R1   -> 0
    imem_b[14] = 16'h8001; // SUBI R0,1   -> FF, N=1 C=1
    imem_b[15] = 16'h6400; // MOV R1,R0   flags kept
    imem_b[16] = 16'hF000; // HALT
    run_prog(2000);
    chk(dbg_regs[7:0]   == 8'hFF, "R3 mix R0 borrow result", dbg_regs[7:0], 8'hFF);
    chk(dbg_regs[15:8]  == 8'hFF, "R3 mix R1 move", dbg_regs[15:8], 8'hFF);
    chk(dbg_regs[23:16] == 8'h0A, "R9 load then use", dbg_regs[23:16], 8'h0A);
    chk(dbg_regs[31:24] == 8'h00, "R3 mix R3 and", dbg_regs[31:24], 0);
    chk(dbg_flags == 3'b110, "R6 flags kept by MOV", dbg_flags, 3'b110);
    chk(dmem_b[8'h10] == 8'h05, "R8 memory byte", dmem_b[8'h10], 5);
    chk(dbg_pc == 8'd17, "R7 branch path end pc", dbg_pc, 17);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule